// File: doc/BRIEF.md
# Masked SIMD Processing Element Array

This block is a row of identical processing elements that share one instruction stream. A central controller places an opcode and a 32-bit immediate on a broadcast bus and raises a valid strobe for one cycle. Every element decodes the same instruction in the same cycle. None of the elements fetches or sequences its own code. Each element holds one 32-bit record in a local register and keeps a one-bit enable flag. Only elements whose flag is set commit arithmetic results.

A data-dependent choice costs no branch. The controller first sets each flag by comparing the record against a broadcast threshold. It then issues the arithmetic for the "true" side, flips every flag, and issues the arithmetic for the "false" side. A typical use is a record update that scales large values by 1.05 and all other values by 1.10, with the factors given in 16.16 fixed point. Two registered reduction outputs give the OR and the AND of all flags, so the controller can test cheaply whether any element, or every element, is still enabled.

While no instruction is on the bus, a host loads records through an indexed write port and reads them back through a combinational read port. The instruction bus has priority over the host port.

Top module: `simd_pe_array`

## Requirements
- R1: After reset every record reads 0, every flag is set, and both `any_active` and `all_active` read 1.
- R2: When `host_we` is high and `instr_valid` is low, the record of element `host_idx` takes `host_wdata` at the clock edge. `host_rdata` always shows the record of element `host_idx` without a register stage.
- R3: A host write in a cycle where `instr_valid` is high is dropped. The addressed record keeps the value the instruction gives it.
- R4: Opcode 1 (threshold compare) sets each flag to the unsigned result record > immediate. It does this in every element, whatever the flag was before.
- R5: Opcode 2 (flip) replaces every flag with its complement.
- R6: Opcode 3 (enable all) sets every flag.
- R7: Opcode 4 (fixed-point scale) replaces each enabled record with bits [47:16] of the unsigned 64-bit product of the record and the immediate. The immediate is in 16.16 format, so 0x0001_0000 means 1.0.
- R8: During opcode 4, an element with a clear flag keeps its record unchanged.
- R9: `any_active` is the OR of all flags and `all_active` is the AND. Both are registered. After an instruction at edge k, they show its flags from edge k+1 on.
- R10: Opcode 0 and the unused opcodes 5, 6 and 7 change no record and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Broadcast instruction present this cycle |
| instr_op | input | 3 | Broadcast opcode |
| instr_imm | input | 32 | Broadcast immediate (threshold or 16.16 factor) |
| host_we | input | 1 | Host record write strobe |
| host_idx | input | 3 | Element selected by the host port |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Record of the selected element |
| any_active | output | 1 | Registered OR of all flags |
| all_active | output | 1 | Registered AND of all flags |

## Verification
A host write and a broadcast instruction can land in the same cycle. The bench provokes this in two ways. First, it raises `host_we` together with a fixed-point scale aimed at the same element, and checks that the record equals the scaled value and not the host data. Second, it pairs a host write with a no-op, and checks that the old record survives. The salary-style two-phase program runs from a stimulus table. After every step, a bench model predicts each record and both reductions. That makes masked-off elements, flag flips and the one-cycle reduction lag visible at the ports.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam logic [2:0] OP_NOP     = 3'd0;
  localparam logic [2:0] OP_SETGT   = 3'd1;
  localparam logic [2:0] OP_FLIP    = 3'd2;
  localparam logic [2:0] OP_ALLON   = 3'd3;
  localparam logic [2:0] OP_SCALE   = 3'd4;

  typedef struct packed {
    logic set_gt;
    logic flip;
    logic all_on;
    logic scale;
    logic host_wr;
  } pe_ctl_t;
endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_pkg::*;
(
  input  logic       instr_valid,
  input  logic [2:0] instr_op,
  input  logic       host_we,
  output pe_ctl_t    ctl
);
  always_comb begin
    ctl = '0;
    if (instr_valid) begin
      case (instr_op)
        OP_SETGT: ctl.set_gt = 1'b1;
        OP_FLIP:  ctl.flip   = 1'b1;
        OP_ALLON: ctl.all_on = 1'b1;
        OP_SCALE: ctl.scale  = 1'b1;
        default:  ctl = '0;
      endcase
    end else begin
      ctl.host_wr = host_we;
    end
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pe_ctl_t           ctl,
  input  logic [DATA_W-1:0] imm,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] data_o,
  output logic              mask_o
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] data_q;
  logic              mask_q;
  logic [PROD_W-1:0] prod;
  logic              unused_prod;

  assign prod = PROD_W'(data_q) * PROD_W'(imm);
  assign unused_prod = ^{prod[PROD_W-1:DATA_W+FRAC_W], prod[FRAC_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mask_q <= 1'b1;
    end else begin
      if (ctl.host_wr && host_sel)
        data_q <= host_wdata;
      else if (ctl.scale && mask_q)
        data_q <= prod[DATA_W+FRAC_W-1:FRAC_W];

      if (ctl.set_gt)
        mask_q <= (data_q > imm);
      else if (ctl.flip)
        mask_q <= ~mask_q;
      else if (ctl.all_on)
        mask_q <= 1'b1;
    end
  end

  assign data_o = data_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/simd_reduce.sv
module simd_reduce #(
  parameter int NUM_PE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PE-1:0] mask,
  output logic              any_q,
  output logic              all_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q <= 1'b1;
      all_q <= 1'b1;
    end else begin
      any_q <= |mask;
      all_q <= &mask;
    end
  end
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pkg::*;
#(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16,
  localparam int IDX_W = $clog2(NUM_PE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [2:0]        instr_op,
  input  logic [DATA_W-1:0] instr_imm,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              any_active,
  output logic              all_active
);
  pe_ctl_t           ctl;
  logic [DATA_W-1:0] pe_data [NUM_PE];
  logic [NUM_PE-1:0] pe_mask;

  simd_decode u_dec (
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .host_we     (host_we),
    .ctl         (ctl)
  );

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    simd_pe #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_pe (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (ctl),
      .imm        (instr_imm),
      .host_sel   (host_idx == IDX_W'(g)),
      .host_wdata (host_wdata),
      .data_o     (pe_data[g]),
      .mask_o     (pe_mask[g])
    );
  end

  simd_reduce #(.NUM_PE(NUM_PE)) u_red (
    .clk   (clk),
    .rst_n (rst_n),
    .mask  (pe_mask),
    .any_q (any_active),
    .all_q (all_active)
  );

  assign host_rdata = pe_data[host_idx];
endmodule

// File: rtl/simd_pe_array_chk.sv
module simd_pe_array_chk #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 16,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [2:0]        instr_op,
  input logic [DATA_W-1:0] instr_imm,
  input logic [IDX_W-1:0]  host_idx,
  input logic [DATA_W-1:0] host_rdata,
  input logic              any_active,
  input logic              all_active
);
  localparam logic [DATA_W-1:0] ONE_FX = DATA_W'(1) << FRAC_W;

  // R6
  allon_reduce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_op == 3'd3) |=> ##1 (any_active && all_active));

  // R4
  setgt_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_op == 3'd1 && instr_imm == '1) |=> ##1 !any_active);

  // R3
  host_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_op != 3'd4)
      |=> (host_idx != $past(host_idx)) || $stable(host_rdata));

  // R7
  scale_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_op == 3'd4 && instr_imm == ONE_FX)
      |=> (host_idx != $past(host_idx)) || $stable(host_rdata));

  // R9
  all_implies_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_active |-> any_active);
endmodule

bind simd_pe_array simd_pe_array_chk #(
  .DATA_W(DATA_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_op    (instr_op),
  .instr_imm   (instr_imm),
  .host_idx    (host_idx),
  .host_rdata  (host_rdata),
  .any_active  (any_active),
  .all_active  (all_active)
);

// File: tb/tb_simd_pe_array.sv
module tb_simd_pe_array;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int STEPS = 12;

  // {op[2:0], imm[31:0]}
  localparam logic [34:0] PROG [STEPS] = '{
    {3'd3, 32'd0},          // enable all
    {3'd1, 32'd100000},     // flag > 100000
    {3'd4, 32'd68813},      // x1.05 on flagged
    {3'd2, 32'd0},          // flip
    {3'd4, 32'd72090},      // x1.10 on the rest
    {3'd3, 32'd0},
    {3'd1, 32'hFFFF_FFFF},  // nobody above
    {3'd4, 32'd0},          // scale by zero, nobody enabled
    {3'd2, 32'd0},
    {3'd5, 32'h1234_5678},  // unused opcode
    {3'd4, 32'h0001_0000},  // unity scale
    {3'd1, 32'd0}
  };
  localparam logic [31:0] INIT [N] = '{
    32'd150000, 32'd100000, 32'd100001, 32'd50000,
    32'd0, 32'd200000, 32'd99999, 32'hFFFF_0000
  };

  logic clk = 0, rst_n = 0;
  logic instr_valid = 0, host_we = 0;
  logic [2:0] instr_op = 0, host_idx = 0;
  logic [31:0] instr_imm = 0, host_wdata = 0;
  logic [31:0] host_rdata;
  logic any_active, all_active;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_data [N];
  logic [N-1:0] m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_pe_array dut (.*);

  function automatic logic [31:0] fx(input logic [31:0] d, input logic [31:0] k);
    logic [63:0] p;
    p = {32'd0, d} * {32'd0, k};
    return p[47:16];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_write(input int i, input logic [31:0] v);
    @(negedge clk);
    host_we = 1; host_idx = 3'(i); host_wdata = v;
    @(negedge clk);
    host_we = 0;
    m_data[i] = v;
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] imm);
    @(negedge clk);
    instr_valid = 1; instr_op = op; instr_imm = imm;
    for (int i = 0; i < N; i++) begin
      case (op)
        3'd1: m_mask[i] = m_data[i] > imm;
        3'd2: m_mask[i] = ~m_mask[i];
        3'd3: m_mask[i] = 1'b1;
        3'd4: if (m_mask[i]) m_data[i] = fx(m_data[i], imm);
        default: ;
      endcase
    end
    @(negedge clk);
    instr_valid = 0;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < N; i++) begin
      host_idx = 3'(i);
      #1;
      chk({tag, " R7 R8 R10 record"}, host_rdata, m_data[i]);
    end
    chk({tag, " R9 any"}, {31'd0, any_active}, {31'd0, |m_mask});
    chk({tag, " R9 all"}, {31'd0, all_active}, {31'd0, &m_mask});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_mask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < N; i++) begin
      host_idx = 3'(i); #1;
      chk("R1 record", host_rdata, 32'd0);
      m_data[i] = 0;
    end
    chk("R1 any", {31'd0, any_active}, 32'd1);
    chk("R1 all", {31'd0, all_active}, 32'd1);

    // R2 loads
    for (int i = 0; i < N; i++) host_write(i, INIT[i]);
    check_all("R2 load");

    // Program table: two-phase conditional plus corners (R4 R5 R6 R7 R8 R10)
    for (int s = 0; s < STEPS; s++) begin
      issue(PROG[s][34:32], PROG[s][31:0]);
      check_all($sformatf("step%0d R4 R5 R6", s));
    end

    // R9 lag: reduction still old one cycle after mask change
    issue(3'd3, 0);
    @(negedge clk);
    instr_valid = 1; instr_op = 3'd1; instr_imm = 32'hFFFF_FFFF;
    @(negedge clk);
    instr_valid = 0;
    chk("R9 lag any", {31'd0, any_active}, 32'd1);
    @(negedge clk);
    chk("R9 updated any", {31'd0, any_active}, 32'd0);
    m_mask = '0;

    // R3 host write with NOP same cycle is dropped
    @(negedge clk);
    instr_valid = 1; instr_op = 3'd0; host_we = 1; host_idx = 3'd2; host_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    instr_valid = 0; host_we = 0; #1;
    chk("R3 nop collision", host_rdata, m_data[2]);

    // R3 host write with scale on same element: scale wins
    issue(3'd3, 0);
    @(negedge clk);
    instr_valid = 1; instr_op = 3'd4; instr_imm = 32'h0002_0000;
    host_we = 1; host_idx = 3'd5; host_wdata = 32'h1111_1111;
    for (int i = 0; i < N; i++) m_data[i] = fx(m_data[i], 32'h0002_0000);
    @(negedge clk);
    instr_valid = 0; host_we = 0; #1;
    chk("R3 scale collision", host_rdata, m_data[5]);
    @(negedge clk);
    check_all("R3 after");

    // R1 reset again mid-run
    rst_n = 0; #1;
    host_idx = 3'd5; #1;
    chk("R1 rereset record", host_rdata, 32'd0);
    chk("R1 rereset any", {31'd0, any_active}, 32'd1);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule